// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block sits beside the integer datapath of a small 32-bit core. A compare operation hands it two register values. It records how they relate in a five-bit condition register that software cannot read or write. Signed and unsigned ordering are both captured in that one step.

Later, a conditional branch names one of ten conditions. The block tests the recorded bits against that condition. It then returns either the absolute target carried by the branch or the fall-through address. A branch occupies six bytes: a two-byte opcode followed by a four-byte target. The fall-through address is therefore the branch address plus six.

One compare result may serve any number of later branches. The condition register changes only on the next compare.

Top module: `cmp_branch_resolver`

## Requirements
- R1: On a clock edge where `cmp_valid` is high, the condition register captures five bits: bit 0 means A > B signed, bit 1 means A < B signed, bit 2 means A == B, bit 3 means A > B unsigned, and bit 4 means A < B unsigned. After a compare, exactly one of bits {0,1,2} is set and exactly one of bits {2,3,4} is set.
- R2: Condition codes on `br_cond` are: 0 eq, 1 ne, 2 lt, 3 gt, 4 ltu, 5 gtu, 6 ge, 7 le, 8 geu, 9 leu. The conditions eq, lt, gt, ltu and gtu are taken when bit 2, 1, 0, 4 and 3 respectively is set. The ne condition is taken when bit 2 is clear.
- R3: The ge condition is taken exactly when bit 1 is clear. The geu condition is taken exactly when bit 4 is clear.
- R4: The le condition is taken when bit 1 or bit 2 is set. The leu condition is taken when bit 4 or bit 2 is set.
- R5: The clock edge on which `br_valid` is high updates `taken` and `next_pc`, and both are visible from then on. If the branch is taken, `next_pc` equals `br_target`. Otherwise `next_pc` equals `br_pc + 6`.
- R6: The condition register keeps its value until the next compare, so successive branches test the same result.
- R7: Reset clears the condition register, `taken` and `next_pc` to zero. A branch issued before any compare is therefore taken only for ne, ge and geu.
- R8: When a compare and a branch arrive on the same edge, the branch tests the condition register as it was before that compare.
- R9: Condition codes 10 to 15 are never taken and always produce the fall-through address.
- R10: While `br_valid` is low, `taken` and `next_pc` hold their values, whatever `br_pc` and `br_target` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Conditional branch strobe |
| br_cond | input | 4 | Branch condition code |
| br_pc | input | 32 | Address of the branch instruction |
| br_target | input | 32 | Absolute branch target |
| taken | output | 1 | Branch resolved as taken |
| next_pc | output | 32 | Resolved next instruction address |

## Verification
A compare updates the hidden condition register on the edge where it is presented, and a branch result appears on the edge where the branch is presented. The bench therefore changes inputs on falling edges and reads `taken` and `next_pc` on the falling edge after the branch strobe, which is one full register stage later. Because the condition register cannot be read directly, each compare is observed through a sweep of all ten conditions.

The same-edge case is driven so that the compare and the branch share one rising edge. The expected result there is built from the previous compare.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int FLAG_W = 5;
  localparam int COND_W = 4;

  // Bit positions of the condition register; branch decode depends on them.
  typedef struct packed {
    logic ltu;  // bit 4
    logic gtu;  // bit 3
    logic eq;   // bit 2
    logic lts;  // bit 1
    logic gts;  // bit 0
  } cbr_flags_t;

  typedef enum logic [COND_W-1:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_LT  = 4'd2,
    CC_GT  = 4'd3,
    CC_LTU = 4'd4,
    CC_GTU = 4'd5,
    CC_GE  = 4'd6,
    CC_LE  = 4'd7,
    CC_GEU = 4'd8,
    CC_LEU = 4'd9
  } cbr_cond_e;

  localparam int NUM_COND = 10;

  // Evaluate one branch condition against a latched flag set.
  function automatic logic cbr_cond_met(cbr_flags_t f, logic [COND_W-1:0] cc);
    logic hit;
    case (cc)
      CC_EQ:   hit = f.eq;
      CC_NE:   hit = ~f.eq;
      CC_LT:   hit = f.lts;
      CC_GT:   hit = f.gts;
      CC_LTU:  hit = f.ltu;
      CC_GTU:  hit = f.gtu;
      CC_GE:   hit = ~f.lts;
      CC_LE:   hit = f.lts | f.eq;
      CC_GEU:  hit = ~f.ltu;
      CC_LEU:  hit = f.ltu | f.eq;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/cbr_flag_reg.sv
module cbr_flag_reg
  import cbr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output cbr_flags_t        flags_q
);

  cbr_flags_t flags_d;

  always_comb begin
    flags_d.eq  = (cmp_a == cmp_b);
    flags_d.gts = ($signed(cmp_a) > $signed(cmp_b));
    flags_d.lts = ($signed(cmp_a) < $signed(cmp_b));
    flags_d.gtu = (cmp_a > cmp_b);
    flags_d.ltu = (cmp_a < cmp_b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flags_q <= '0;
    else if (cmp_valid) flags_q <= flags_d;
  end

endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
(
  input  cbr_flags_t        flags,
  input  logic [COND_W-1:0] br_cond,
  output logic              cond_met
);

  always_comb cond_met = cbr_cond_met(flags, br_cond);

endmodule

// File: rtl/cbr_pc_select.sv
module cbr_pc_select #(
  parameter int ADDR_W    = 32,
  parameter int BR_BYTES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              cond_met,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] br_target,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BR_BYTES);

  logic [ADDR_W-1:0] fall_pc;
  logic [ADDR_W-1:0] sel_pc;

  always_comb begin
    fall_pc = br_pc + STEP;
    sel_pc  = cond_met ? br_target : fall_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken   <= 1'b0;
      next_pc <= '0;
    end else if (br_valid) begin
      taken   <= cond_met;
      next_pc <= sel_pc;
    end
  end

endmodule

// File: rtl/cmp_branch_resolver.sv
module cmp_branch_resolver
  import cbr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int BR_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              br_valid,
  input  logic [COND_W-1:0] br_cond,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] br_target,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);

  cbr_flags_t flags_q;
  logic       cond_met;

  cbr_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .flags_q   (flags_q)
  );

  cbr_cond_eval u_eval (
    .flags    (flags_q),
    .br_cond  (br_cond),
    .cond_met (cond_met)
  );

  cbr_pc_select #(.ADDR_W(ADDR_W), .BR_BYTES(BR_BYTES)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_valid  (br_valid),
    .cond_met  (cond_met),
    .br_pc     (br_pc),
    .br_target (br_target),
    .taken     (taken),
    .next_pc   (next_pc)
  );

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker
  import cbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b,
  input logic              br_valid,
  input logic [COND_W-1:0] br_cond,
  input logic [ADDR_W-1:0] br_pc,
  input logic [ADDR_W-1:0] br_target,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic [FLAG_W-1:0] flags
);

  AST_SIGNED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[2:0])); // R1
  AST_UNSIGNED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[4:2])); // R1
  AST_EQ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> flags[2] == ($past(cmp_a) == $past(cmp_b))); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(flags)); // R6
  AST_PC_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> next_pc == (taken ? $past(br_target) : $past(br_pc) + ADDR_W'(6))); // R5
  AST_RESERVED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond >= 4'd10) |=> !taken); // R9
  AST_SAME_EDGE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && br_valid && br_cond == 4'd0) |=> taken == $past(flags[2])); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> ($stable(taken) && $stable(next_pc))); // R10

endmodule

bind cmp_branch_resolver cbr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_a     (cmp_a),
  .cmp_b     (cmp_b),
  .br_valid  (br_valid),
  .br_cond   (br_cond),
  .br_pc     (br_pc),
  .br_target (br_target),
  .taken     (taken),
  .next_pc   (next_pc),
  .flags     (flags_q)
);

// File: tb/tb_cmp_branch_resolver.sv
module tb_cmp_branch_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0;
  logic [31:0] cmp_b = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [31:0] br_pc = '0;
  logic [31:0] br_target = '0;
  logic        taken;
  logic [31:0] next_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cmp_branch_resolver dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_cond(br_cond), .br_pc(br_pc), .br_target(br_target),
    .taken(taken), .next_pc(next_pc)
  );

  // {a, b, taken mask}; mask bit k is the outcome for condition code k
  // (R1 capture, R2 direct, R3 ge/geu, R4 le/leu).
  localparam logic [73:0] VEC [8] = '{
    {32'd5,          32'd5,          10'h3C1},
    {32'd3,          32'd7,          10'h296},
    {32'd7,          32'd3,          10'h16A},
    {32'hFFFFFFFF,   32'd1,          10'h1A6},
    {32'd1,          32'h80000000,   10'h25A},
    {32'h80000000,   32'h7FFFFFFF,   10'h1A6},
    {32'd0,          32'd0,          10'h3C1},
    {32'hFFFFFFFF,   32'hFFFFFFFE,   10'h16A}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_cmp(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // Issue a branch, then check the outputs one edge later.
  task automatic do_br(string req, logic [3:0] cc, logic [31:0] pc,
                       logic [31:0] tgt, logic exp_taken);
    @(negedge clk);
    br_valid = 1'b1; br_cond = cc; br_pc = pc; br_target = tgt;
    @(negedge clk);
    br_valid = 1'b0;
    check(req, {31'd0, taken}, {31'd0, exp_taken});
    check(req, next_pc, exp_taken ? tgt : pc + 32'd6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [9:0] rmask;
    repeat (3) @(negedge clk);
    // R7: reset state of the outputs
    check("R7", {31'd0, taken}, 32'd0);
    check("R7", next_pc, 32'd0);
    rst_n = 1'b1;

    // R7: branches before any compare; only ne, ge, geu are taken
    rmask = 10'h142;
    for (int k = 0; k < 10; k++)
      do_br("R7", 4'(k), 32'h400 + 32'(k) * 8, 32'h900 + 32'(k) * 16, rmask[k]);

    // Table walk: R1, R2, R3, R4, R5, R6 (ten branches share one compare)
    for (int v = 0; v < 8; v++) begin
      do_cmp(VEC[v][73:42], VEC[v][41:10]);
      for (int k = 0; k < 10; k++)
        do_br("R2/R3/R4/R5/R6", 4'(k), 32'h1000 + 32'(k) * 8,
              32'h2000 + 32'(v) * 256 + 32'(k) * 16, VEC[v][k]);
    end

    // R9: reserved codes fall through, even after an equal compare
    do_cmp(32'd9, 32'd9);
    for (int k = 10; k < 16; k++)
      do_br("R9", 4'(k), 32'h3000 + 32'(k), 32'h4000, 1'b0);

    // R8: compare and branch on one edge; branch sees old flags (3 < 7)
    do_cmp(32'd3, 32'd7);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = 32'd7; cmp_b = 32'd3;
    br_valid = 1'b1; br_cond = 4'd2; br_pc = 32'h5000; br_target = 32'h6000;
    @(negedge clk);
    cmp_valid = 1'b0; br_valid = 1'b0;
    check("R8", {31'd0, taken}, 32'd1);
    check("R8", next_pc, 32'h6000);
    // the new compare (7 > 3) is now in force
    do_br("R8", 4'd2, 32'h5100, 32'h6100, 1'b0);

    // R10: outputs hold while br_valid is low and branch inputs wander
    do_br("R10", 4'd3, 32'h7000, 32'h7A00, 1'b1);
    @(negedge clk);
    br_pc = 32'hDEAD0000; br_target = 32'hBEEF0000; br_cond = 4'd4;
    repeat (3) @(negedge clk);
    check("R10", {31'd0, taken}, 32'd1);
    check("R10", next_pc, 32'h7A00);

    // R7: reset mid-run clears flags and outputs
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R7", {31'd0, taken}, 32'd0);
    check("R7", next_pc, 32'd0);
    rst_n = 1'b1;
    do_br("R7", 4'd1, 32'h8000, 32'h8800, 1'b1);  // ne after reset
    do_br("R7", 4'd7, 32'h8010, 32'h8810, 1'b0);  // le after reset

    finish_run();
  end

endmodule